// File: doc/BRIEF.md
# Composite Branch Path Confidence Estimator

This block tells a branch-directed lookahead engine how far it may trust the speculative path it is walking. For every branch on the path it builds a confidence number from two history-indexed counter tables plus the branch predictor's own two 2-bit counters. That number selects a bucket, and each bucket holds an accuracy ratio learned from resolved branches. The ratio is the per-branch confidence, an 8-bit fraction where a value v stands for v/256.

Each accepted lookahead step multiplies the running path confidence by the per-branch confidence and moves one block deeper. A threshold that grows with depth, together with a hard depth cap, decides whether the engine may take the next step or has to stall. A start pulse, used on a flush or on a new walk, restores full confidence (8'hFF) and depth zero. Branch prediction itself stays outside. The predictor's counters arrive on the query and update ports.

Top module: `path_conf_estimator`

## Requirements
- R1: On an update, the local table entry at `upd_lidx_i` (5-bit, 1024 entries by default) increments and saturates at 31 when `upd_correct_i` is 1. When it is 0, the entry shifts right by one.
- R2: On an update, the global table entry at `upd_gidx_i` (3-bit, 4096 entries by default) increments and saturates at 7 when the prediction was correct. On a mispredict it clears to 0.
- R3: The bucket index is local counter + global counter + self counter A + self counter B, in the range 0 to 44. For both queries and updates it is taken from the table values held before any update in the same cycle.
- R4: Each bucket counts resolved branches and correct ones. After every INTERVAL updates (1024 by default) a sweep visits buckets 0 to 44, one per cycle. It sets each ratio to min(255, floor(256*correct/total)), or 128 if total is 0, and halves both counts.
- R5: Until a bucket is swept, its ratio is 128.
- R6: A step pulse that is not stalled and not overridden by start sets path confidence to (path * ratio) >> 8 and adds one to depth. Both are visible one cycle later.
- R7: `stall_o` is 1 when depth equals MAX_DEPTH (12) or path confidence is below min(255, THR_BASE + depth*THR_STEP), which is 16 + 8*depth by default. A step while stalled leaves path and depth unchanged.
- R8: A start pulse sets path confidence to 8'hFF and depth to 0 one cycle later, and wins over a step in the same cycle.
- R9: Every step pulse, stalled or not, loads `br_conf_o` with the queried bucket's ratio one cycle later. After reset, `br_conf_o` is 0, path is 8'hFF, depth is 0 and stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Flush or new lookahead start |
| step_i | input | 1 | Request one lookahead step for the queried branch |
| q_lidx_i | input | LIDX_W | Local history index of the queried branch |
| q_gidx_i | input | GIDX_W | Global history index of the queried branch |
| q_self_a_i | input | 2 | Predictor counter A of the queried branch |
| q_self_b_i | input | 2 | Predictor counter B of the queried branch |
| upd_valid_i | input | 1 | Resolved branch update |
| upd_lidx_i | input | LIDX_W | Local history index of the resolved branch |
| upd_gidx_i | input | GIDX_W | Global history index of the resolved branch |
| upd_self_a_i | input | 2 | Predictor counter A at resolve |
| upd_self_b_i | input | 2 | Predictor counter B at resolve |
| upd_correct_i | input | 1 | 1 when the prediction was correct |
| br_conf_o | output | 8 | Per-branch confidence of the last step query |
| path_conf_o | output | 8 | Running path confidence |
| depth_o | output | DEPTH_W | Current lookahead depth |
| stall_o | output | 1 | Lookahead must not advance |

## Verification
The assertions check the path controller on every cycle. They cover the depth cap, stall at the cap, a single-block advance on each accepted step, a path confidence that never rises while advancing, frozen state when stalled, and start restoring full confidence. Only the bench scenarios can show that the tables follow their asymmetric rules, that a bucket index is formed from the pre-update values, and that each swept ratio equals the exact quotient of its counts. This is done by sweeping every index and counter combination of a small configuration against an arithmetic model after each interval.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef logic [7:0] frac_t;
  localparam frac_t FRAC_ONE  = 8'hFF;
  localparam frac_t FRAC_HALF = 8'h80;
endpackage

// File: rtl/pce_hist_tables.sv
module pce_hist_tables #(
  parameter int LIDX_W = 10,
  parameter int GIDX_W = 12,
  parameter int LCTR_W = 5,
  parameter int GCTR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LIDX_W-1:0] q_lidx_i,
  input  logic [GIDX_W-1:0] q_gidx_i,
  output logic [LCTR_W-1:0] q_lctr_o,
  output logic [GCTR_W-1:0] q_gctr_o,
  input  logic              u_valid_i,
  input  logic [LIDX_W-1:0] u_lidx_i,
  input  logic [GIDX_W-1:0] u_gidx_i,
  input  logic              u_correct_i,
  output logic [LCTR_W-1:0] u_lctr_o,
  output logic [GCTR_W-1:0] u_gctr_o
);
  localparam int L_N = 2 ** LIDX_W;
  localparam int G_N = 2 ** GIDX_W;
  localparam logic [LCTR_W-1:0] L_MAX = '1;
  localparam logic [GCTR_W-1:0] G_MAX = '1;

  logic [LCTR_W-1:0] ltab [L_N];
  logic [GCTR_W-1:0] gtab [G_N];

  assign q_lctr_o = ltab[q_lidx_i];
  assign q_gctr_o = gtab[q_gidx_i];
  assign u_lctr_o = ltab[u_lidx_i];
  assign u_gctr_o = gtab[u_gidx_i];

  // local: saturating up, halve on mispredict
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < L_N; i++) ltab[i] <= '0;
    end else if (u_valid_i) begin
      if (u_correct_i) begin
        if (u_lctr_o != L_MAX) ltab[u_lidx_i] <= u_lctr_o + LCTR_W'(1);
      end else begin
        ltab[u_lidx_i] <= u_lctr_o >> 1;
      end
    end
  end

  // global: saturating up, clear on mispredict
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < G_N; i++) gtab[i] <= '0;
    end else if (u_valid_i) begin
      if (u_correct_i) begin
        if (u_gctr_o != G_MAX) gtab[u_gidx_i] <= u_gctr_o + GCTR_W'(1);
      end else begin
        gtab[u_gidx_i] <= '0;
      end
    end
  end
endmodule

// File: rtl/pce_bucket_stats.sv
module pce_bucket_stats
  import pce_pkg::*;
#(
  parameter int NB       = 45,
  parameter int BKT_W    = 6,
  parameter int CNT_W    = 12,
  parameter int INTERVAL = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_valid_i,
  input  logic [BKT_W-1:0] upd_bkt_i,
  input  logic             upd_correct_i,
  input  logic [BKT_W-1:0] q_bkt_i,
  output frac_t            q_ratio_o
);
  localparam int INT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int NUM_W = CNT_W + 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] corr [NB];
  logic [CNT_W-1:0] tot  [NB];
  frac_t            ratio [NB];

  logic [INT_W-1:0] int_cnt;
  logic             sweep_act;
  logic [BKT_W-1:0] sweep_idx;
  logic             int_done;

  assign int_done  = upd_valid_i && (int_cnt == INT_W'(INTERVAL - 1));
  assign q_ratio_o = ratio[q_bkt_i];

  // restoring divide: 256*correct / total for the swept bucket
  logic [CNT_W-1:0] den;
  logic [NUM_W-1:0] num, quo;
  logic [CNT_W:0]   rem;
  frac_t            ratio_new;

  always_comb begin
    den = tot[sweep_idx];
    num = {corr[sweep_idx], 8'h00};
    rem = '0;
    quo = '0;
    for (int i = NUM_W - 1; i >= 0; i--) begin
      rem = {rem[CNT_W-1:0], num[i]};
      if (rem >= {1'b0, den}) begin
        rem    = rem - {1'b0, den};
        quo[i] = 1'b1;
      end
    end
    if (den == '0)            ratio_new = FRAC_HALF;
    else if (|quo[NUM_W-1:8]) ratio_new = 8'hFF;
    else                      ratio_new = quo[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_cnt   <= '0;
      sweep_act <= 1'b0;
      sweep_idx <= '0;
    end else begin
      if (upd_valid_i) int_cnt <= int_done ? '0 : int_cnt + INT_W'(1);
      if (int_done) begin
        sweep_act <= 1'b1;
        sweep_idx <= '0;
      end else if (sweep_act) begin
        if (sweep_idx == BKT_W'(NB - 1)) sweep_act <= 1'b0;
        else                            sweep_idx <= sweep_idx + BKT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) begin
        corr[b]  <= '0;
        tot[b]   <= '0;
        ratio[b] <= FRAC_HALF;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        logic             hit, swp;
        logic [CNT_W-1:0] bt, bc;
        hit = upd_valid_i && (upd_bkt_i == BKT_W'(b)) && (tot[b] != CNT_MAX);
        swp = sweep_act && (sweep_idx == BKT_W'(b));
        bt  = swp ? (tot[b] >> 1)  : tot[b];
        bc  = swp ? (corr[b] >> 1) : corr[b];
        tot[b]  <= bt + CNT_W'(hit);
        corr[b] <= bc + CNT_W'(hit && upd_correct_i);
        if (swp) ratio[b] <= ratio_new;
      end
    end
  end
endmodule

// File: rtl/pce_path_gate.sv
module pce_path_gate
  import pce_pkg::*;
#(
  parameter int MAX_DEPTH = 12,
  parameter int DEPTH_W   = 4,
  parameter int THR_BASE  = 16,
  parameter int THR_STEP  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               step_i,
  input  frac_t              br_conf_i,
  output frac_t              conf_o,
  output frac_t              path_conf_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               stall_o
);
  frac_t              path_q, conf_q, thr;
  logic [DEPTH_W-1:0] depth_q;
  logic [15:0]        prod;
  int                 thr_raw;

  always_comb begin
    thr_raw = THR_BASE + int'(depth_q) * THR_STEP;
    thr     = (thr_raw > 255) ? 8'hFF : 8'(thr_raw);
  end

  assign prod    = {8'h00, path_q} * {8'h00, br_conf_i};
  assign stall_o = (depth_q == DEPTH_W'(MAX_DEPTH)) || (path_q < thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_q  <= FRAC_ONE;
      depth_q <= '0;
      conf_q  <= '0;
    end else begin
      if (step_i) conf_q <= br_conf_i;
      if (start_i) begin
        path_q  <= FRAC_ONE;
        depth_q <= '0;
      end else if (step_i && !stall_o) begin
        path_q  <= prod[15:8];
        depth_q <= depth_q + DEPTH_W'(1);
      end
    end
  end

  assign conf_o      = conf_q;
  assign path_conf_o = path_q;
  assign depth_o     = depth_q;
endmodule

// File: rtl/path_conf_estimator.sv
module path_conf_estimator
  import pce_pkg::*;
#(
  parameter int LIDX_W    = 10,
  parameter int GIDX_W    = 12,
  parameter int LCTR_W    = 5,
  parameter int GCTR_W    = 3,
  parameter int SELF_W    = 2,
  parameter int CNT_W     = 12,
  parameter int INTERVAL  = 1024,
  parameter int MAX_DEPTH = 12,
  parameter int THR_BASE  = 16,
  parameter int THR_STEP  = 8,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               step_i,
  input  logic [LIDX_W-1:0]  q_lidx_i,
  input  logic [GIDX_W-1:0]  q_gidx_i,
  input  logic [SELF_W-1:0]  q_self_a_i,
  input  logic [SELF_W-1:0]  q_self_b_i,
  input  logic               upd_valid_i,
  input  logic [LIDX_W-1:0]  upd_lidx_i,
  input  logic [GIDX_W-1:0]  upd_gidx_i,
  input  logic [SELF_W-1:0]  upd_self_a_i,
  input  logic [SELF_W-1:0]  upd_self_b_i,
  input  logic               upd_correct_i,
  output logic [7:0]         br_conf_o,
  output logic [7:0]         path_conf_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               stall_o
);
  localparam int NB    = (2**LCTR_W - 1) + (2**GCTR_W - 1) + 2 * (2**SELF_W - 1) + 1;
  localparam int BKT_W = $clog2(NB);

  logic [LCTR_W-1:0] q_lctr, u_lctr;
  logic [GCTR_W-1:0] q_gctr, u_gctr;
  logic [BKT_W-1:0]  q_bkt, u_bkt;
  frac_t             q_ratio;

  pce_hist_tables #(
    .LIDX_W(LIDX_W), .GIDX_W(GIDX_W), .LCTR_W(LCTR_W), .GCTR_W(GCTR_W)
  ) u_tables (
    .clk_i, .rst_ni,
    .q_lidx_i(q_lidx_i), .q_gidx_i(q_gidx_i),
    .q_lctr_o(q_lctr), .q_gctr_o(q_gctr),
    .u_valid_i(upd_valid_i), .u_lidx_i(upd_lidx_i), .u_gidx_i(upd_gidx_i),
    .u_correct_i(upd_correct_i),
    .u_lctr_o(u_lctr), .u_gctr_o(u_gctr)
  );

  assign q_bkt = BKT_W'(q_lctr) + BKT_W'(q_gctr) + BKT_W'(q_self_a_i) + BKT_W'(q_self_b_i);
  assign u_bkt = BKT_W'(u_lctr) + BKT_W'(u_gctr) + BKT_W'(upd_self_a_i) + BKT_W'(upd_self_b_i);

  pce_bucket_stats #(
    .NB(NB), .BKT_W(BKT_W), .CNT_W(CNT_W), .INTERVAL(INTERVAL)
  ) u_stats (
    .clk_i, .rst_ni,
    .upd_valid_i(upd_valid_i), .upd_bkt_i(u_bkt), .upd_correct_i(upd_correct_i),
    .q_bkt_i(q_bkt), .q_ratio_o(q_ratio)
  );

  pce_path_gate #(
    .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W), .THR_BASE(THR_BASE), .THR_STEP(THR_STEP)
  ) u_gate (
    .clk_i, .rst_ni,
    .start_i(start_i), .step_i(step_i), .br_conf_i(q_ratio),
    .conf_o(br_conf_o), .path_conf_o(path_conf_o), .depth_o(depth_o), .stall_o(stall_o)
  );
endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
  parameter int MAX_DEPTH = 12,
  parameter int DEPTH_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               step_i,
  input logic [7:0]         path_conf_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               stall_o
);
  a_r7_depth_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DEPTH_W'(MAX_DEPTH));

  a_r7_stall_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o == DEPTH_W'(MAX_DEPTH) |-> stall_o);

  a_r8_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (path_conf_o == 8'hFF) && (depth_o == '0));

  a_r6_step_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !stall_o && !start_i |=> depth_o == $past(depth_o) + DEPTH_W'(1));

  a_r6_path_nonincr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !stall_o && !start_i |=> path_conf_o <= $past(path_conf_o));

  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i || stall_o) && !start_i |=> $stable(depth_o) && $stable(path_conf_o));
endmodule

bind path_conf_estimator pce_checker #(
  .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)
) u_pce_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .step_i(step_i),
  .path_conf_o(path_conf_o), .depth_o(depth_o), .stall_o(stall_o)
);

// File: tb/tb_path_conf_estimator.sv
module tb_path_conf_estimator;
  localparam int LW = 2, GW = 2, NB = 45, DW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start, step, upd_v, upd_c;
  logic [LW-1:0] ql, ul;
  logic [GW-1:0] qg, ug;
  logic [1:0] qa, qb, ua, ub;
  logic [7:0] br_conf, path_conf;
  logic [DW-1:0] depth;
  logic stall;

  int checks = 0, fails = 0;
  int ml[4], mg[4], mc[NB], mt[NB], mr[NB];
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  path_conf_estimator #(.LIDX_W(LW), .GIDX_W(GW), .INTERVAL(64)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step),
    .q_lidx_i(ql), .q_gidx_i(qg), .q_self_a_i(qa), .q_self_b_i(qb),
    .upd_valid_i(upd_v), .upd_lidx_i(ul), .upd_gidx_i(ug),
    .upd_self_a_i(ua), .upd_self_b_i(ub), .upd_correct_i(upd_c),
    .br_conf_o(br_conf), .path_conf_o(path_conf), .depth_o(depth), .stall_o(stall)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic int thr_of(int d);
    return (16 + 8 * d > 255) ? 255 : 16 + 8 * d;
  endfunction

  function automatic int bkt(int l, int g, int a, int b);
    return ml[l] + mg[g] + a + b;
  endfunction

  // one resolved branch; model R1 R2 R3 and bucket counts for R4
  task automatic upd(int l, int g, int a, int b, int c);
    int k;
    upd_v = 1'b1; ul = LW'(l); ug = GW'(g); ua = 2'(a); ub = 2'(b); upd_c = c[0];
    k = bkt(l, g, a, b);
    if (mt[k] < 4095) begin mt[k]++; mc[k] += c; end
    if (c != 0) begin
      if (ml[l] < 31) ml[l]++;
      if (mg[g] < 7) mg[g]++;
    end else begin
      ml[l] = ml[l] / 2;
      mg[g] = 0;
    end
    tick();
    upd_v = 1'b0;
  endtask

  task automatic lfsr_upd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    upd(int'(lf[1:0]), int'(lf[3:2]), int'(lf[5:4]), int'(lf[7:6]), (lf[8] & lf[9]) ? 0 : 1);
  endtask

  // R4: wait out the sweep, then apply it to the model
  task automatic settle();
    repeat (50) tick();
    for (int b = 0; b < NB; b++) begin
      if (mt[b] == 0) mr[b] = 128;
      else mr[b] = (mc[b] * 256 / mt[b] > 255) ? 255 : mc[b] * 256 / mt[b];
      mc[b] = mc[b] / 2;
      mt[b] = mt[b] / 2;
    end
  endtask

  // start together with step: R8 priority, br_conf still loads (R9, R3)
  task automatic q_check(int l, int g, int a, int b, string tag);
    ql = LW'(l); qg = GW'(g); qa = 2'(a); qb = 2'(b);
    start = 1'b1; step = 1'b1;
    tick();
    start = 1'b0; step = 1'b0;
    chk(tag, br_conf, mr[bkt(l, g, a, b)]);
    chk("R8 start wins path", path_conf, 255);
    chk("R8 start wins depth", depth, 0);
  endtask

  task automatic run_path(int l, int g, int a, int b);
    int mp, md, r, es;
    ql = LW'(l); qg = GW'(g); qa = 2'(a); qb = 2'(b);
    start = 1'b1; tick(); start = 1'b0;
    mp = 255; md = 0;
    r = mr[bkt(l, g, a, b)];
    for (int k = 0; k < 14; k++) begin
      es = (md == 12 || mp < thr_of(md)) ? 1 : 0;
      chk("R7 stall", stall, es);
      step = 1'b1; tick(); step = 1'b0;
      if (es == 0) begin mp = (mp * r) / 256; md++; end
      chk("R6 path product", path_conf, mp);
      chk("R6 depth", depth, md);
      chk("R9 br_conf", br_conf, r);
    end
  endtask

  task automatic sweep_queries();
    for (int l = 0; l < 4; l++)
      for (int g = 0; g < 4; g++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            q_check(l, g, a, b, "R3 R4 bucket ratio");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    int best;
    start = 0; step = 0; upd_v = 0; upd_c = 0;
    ql = '0; qg = '0; qa = '0; qb = '0; ul = '0; ug = '0; ua = '0; ub = '0;
    for (int i = 0; i < 4; i++) begin ml[i] = 0; mg[i] = 0; end
    for (int b = 0; b < NB; b++) begin mc[b] = 0; mt[b] = 0; mr[b] = 128; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    chk("R9 reset br_conf", br_conf, 0);
    chk("R9 reset path", path_conf, 255);
    chk("R9 reset depth", depth, 0);
    chk("R9 reset stall", stall, 0);

    // R5: untouched buckets read 0.5
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) q_check(0, 0, a, b, "R5 default ratio");
    run_path(0, 0, 1, 2);

    // directed: R1 saturation to 31, R2 to 7, then halve / clear on a mispredict
    for (int i = 0; i < 40; i++) upd(1, 2, 3, 3, 1);
    upd(1, 2, 3, 3, 0);
    for (int i = 0; i < 23; i++) lfsr_upd();
    settle();
    sweep_queries();

    for (int blk = 0; blk < 3; blk++) begin
      for (int i = 0; i < 64; i++) lfsr_upd();
      settle();
      sweep_queries();
    end

    best = 0;
    for (int l = 1; l < 4; l++) if (ml[l] > ml[best]) best = l;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) run_path(best, a, a, b);
    run_path(0, 1, 0, 0);
    summary();
  end
endmodule